// File: doc/BRIEF.md
# LTC Frame Generator

This block produces a longitudinal time code bit stream. The host sets up a time-code word with hours, minutes, seconds and frame number. The block packs that word into an 80-bit frame and sends the frame least-significant bit first, using biphase-mark line coding, on a single logic-level output. A programmable half-bit divider counts master-clock cycles and sets the bit rate. Each frame rate has a built-in divider value, and the host can override it with two byte writes.

The host loads the next time-code word into a holding buffer while the current frame is still going out. The holding word moves into the serial register at the next frame boundary. When no new word is waiting, the block does one of two things. It resends the same code, or, in freewheel mode, it advances the code by one frame on its own. Freewheel counting follows the chosen frame rate and can skip frame numbers in drop-frame mode. A one-cycle pulse marks the first clock of every frame.

Top module: `ltc_frame_gen`

## Requirements
- R1: When the divider has not been overridden, a half-bit lasts D+1 clock cycles. D is 0xBA6 for rate code 0 (30 frame/s), 0xBA9 for code 1 (29.97 frame/s), 0xDFB for code 2 (25 frame/s) and 0xE90 for code 3 (24 frame/s).
- R2: A divider write to address 0 only stages the low byte and does not change the bit timing. A write to address 1 commits {high, staged low} as the new D. This override stays in force until reset, whatever the rate code.
- R3: The output level inverts at every bit boundary. It inverts a second time halfway through a bit only when that bit is 1.
- R4: Frame bit k is sent as the k-th bit, and each BCD digit is sent LSB first. Frame units sit at bits 3:0 and frame tens at 9:8. Second units sit at 19:16 and second tens at 26:24. Minute units sit at 35:32 and minute tens at 42:40. Hour units sit at 51:48 and hour tens at 57:56. Bit 10 is the drop-frame flag. Bits 64..79 are sent as 0,0, then twelve 1s, then 0,1. Every other bit is 0.
- R5: A word loaded during a frame does not change that frame. It is sent starting with the next frame. If several loads arrive before a boundary, the last one wins.
- R6: frameStart is high for exactly the first clock cycle of each frame. Consecutive frames follow each other with no gap.
- R7: In freewheel mode with no pending load, each frame carries the previous code plus one frame. After frame 29 (codes 0, 1), 24 (code 2) or 23 (code 3), the frame number returns to 0 and the seconds advance.
- R8: Freewheel carries ripple through seconds, minutes and hours, so 23:59:59 on the last frame is followed by 00:00:00:00.
- R9: With dropFrame high, the drop-frame flag bit is 1. A freewheel step into a new minute whose value is not a multiple of 10 lands on frame 2 instead of 0.
- R10: With freewheel low and no pending load, the last code is sent again unchanged.
- R11: While enable is low, the output holds and no frameStart occurs. Raising enable starts a new frame at bit 0 that carries the pending word, or the last code if no word is pending, without incrementing it.
- R12: After reset, ltcOut and frameStart are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run the generator; low stops it and restarts the frame on the next rise |
| rateSel | input | 2 | Frame rate: 0 = 30, 1 = 29.97, 2 = 25, 3 = 24 frame/s |
| dropFrame | input | 1 | Drop-frame numbering and flag |
| freewheel | input | 1 | Advance the code locally when no word is pending |
| divWrEn | input | 1 | Divider byte write strobe |
| divWrAddr | input | 1 | Divider byte select: 0 low (staged), 1 high (commit) |
| divWrData | input | 8 | Divider byte value |
| loadStb | input | 1 | Load the time-code word into the holding buffer |
| loadHours | input | 5 | Hours, binary 0..23 |
| loadMins | input | 6 | Minutes, binary 0..59 |
| loadSecs | input | 6 | Seconds, binary 0..59 |
| loadFrames | input | 5 | Frame number, binary |
| ltcOut | output | 1 | Biphase-mark coded time code |
| frameStart | output | 1 | One-cycle pulse on the first cycle of each frame |

## Verification
The bench decodes whole frames from the serial output and checks the exact length of each half-bit. A divider off by one cycle, or a default constant swapped between rates, shows up as a wrong half-bit count. A low-byte write that takes effect on its own shows up as a short first half-bit. The bench loads a word in the middle of a frame, and twice in one frame. A buffer that swaps early would corrupt the frame in flight, and one that keeps the first load would send the wrong code afterwards. Freewheel runs cross the wrap point of each frame rate, the rollover from 23:59:59 and drop-frame minutes both at and away from multiples of ten. A wrong wrap limit, a missing carry or a skip applied on tenth minutes would each send a wrong decoded time.

// File: rtl/ltc_gen_pkg.sv
package ltc_gen_pkg;

  localparam int FRAME_BITS = 80;
  localparam int IDX_W = $clog2(FRAME_BITS);
  // sync field as sent, bit 0 first: 0,0,1 x12,0,1
  localparam logic [15:0] SYNC_WORD = 16'hBFFC;

  typedef struct packed {
    logic [4:0] hours;
    logic [5:0] mins;
    logic [5:0] secs;
    logic [4:0] frames;
  } tcWord_t;

  typedef struct packed {
    logic loadFrame;
    logic firstFrame;
    logic shift;
    logic midBit;
  } ctrlStrb_t;

  function automatic logic [15:0] defaultDiv(input logic [1:0] rate);
    case (rate)
      2'd0:    return 16'h0BA6;
      2'd1:    return 16'h0BA9;
      2'd2:    return 16'h0DFB;
      default: return 16'h0E90;
    endcase
  endfunction

  function automatic logic [4:0] lastFrame(input logic [1:0] rate);
    case (rate)
      2'd2:    return 5'd24;
      2'd3:    return 5'd23;
      default: return 5'd29;
    endcase
  endfunction

  function automatic tcWord_t stepTime(input tcWord_t t, input logic [1:0] rate,
                                       input logic drop);
    tcWord_t n;
    n = t;
    if (t.frames >= lastFrame(rate)) begin
      n.frames = 5'd0;
      if (t.secs >= 6'd59) begin
        n.secs = 6'd0;
        if (t.mins >= 6'd59) begin
          n.mins  = 6'd0;
          n.hours = (t.hours >= 5'd23) ? 5'd0 : t.hours + 5'd1;
        end else begin
          n.mins = t.mins + 6'd1;
        end
        if (drop && ((n.mins % 6'd10) != 6'd0)) n.frames = 5'd2;
      end else begin
        n.secs = t.secs + 6'd1;
      end
    end else begin
      n.frames = t.frames + 5'd1;
    end
    return n;
  endfunction

  function automatic logic [FRAME_BITS-1:0] packFrame(input tcWord_t t, input logic drop);
    logic [FRAME_BITS-1:0] f;
    f          = '0;
    f[3:0]     = 4'(t.frames % 5'd10);
    f[9:8]     = 2'(t.frames / 5'd10);
    f[10]      = drop;
    f[19:16]   = 4'(t.secs % 6'd10);
    f[26:24]   = 3'(t.secs / 6'd10);
    f[35:32]   = 4'(t.mins % 6'd10);
    f[42:40]   = 3'(t.mins / 6'd10);
    f[51:48]   = 4'(t.hours % 5'd10);
    f[57:56]   = 2'(t.hours / 5'd10);
    f[FRAME_BITS-1 -: 16] = SYNC_WORD;
    return f;
  endfunction

endpackage

// File: rtl/ltc_bit_timer.sv
module ltc_bit_timer
  import ltc_gen_pkg::*;
#(
  parameter int DIV_W = 16,
  localparam int DIV_BYTES = DIV_W / 8,
  localparam int ADDR_W = (DIV_BYTES > 1) ? $clog2(DIV_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [1:0]        rateSel,
  input  logic              divWrEn,
  input  logic [ADDR_W-1:0] divWrAddr,
  input  logic [7:0]        divWrData,
  output ctrlStrb_t         strb
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);
  localparam logic [ADDR_W-1:0] TOP_LANE = ADDR_W'(DIV_BYTES - 1);

  logic [DIV_W-9:0] stagedLow;
  logic [DIV_W-1:0] divReg, effDiv, halfCnt;
  logic             divOverride, started, halfSel, tick;
  logic [IDX_W-1:0] bitIdx;

  // lower byte lanes only stage; the top lane commits the whole value
  for (genvar g = 0; g < DIV_BYTES - 1; g++) begin : gLane
    logic [7:0] byteQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) byteQ <= '0;
      else if (divWrEn && divWrAddr == ADDR_W'(g)) byteQ <= divWrData;
    end
    assign stagedLow[g*8 +: 8] = byteQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divReg      <= '0;
      divOverride <= 1'b0;
    end else if (divWrEn && divWrAddr == TOP_LANE) begin
      divReg      <= {divWrData, stagedLow};
      divOverride <= 1'b1;
    end
  end

  assign effDiv = divOverride ? divReg : DIV_W'(defaultDiv(rateSel));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      started <= 1'b0;
      halfCnt <= '0;
      halfSel <= 1'b0;
      bitIdx  <= '0;
    end else if (!enable) begin
      started <= 1'b0;
    end else if (!started) begin
      started <= 1'b1;
      halfCnt <= effDiv;
      halfSel <= 1'b0;
      bitIdx  <= '0;
    end else if (halfCnt != '0) begin
      halfCnt <= halfCnt - DIV_W'(1);
    end else begin
      halfCnt <= effDiv;
      halfSel <= !halfSel;
      if (halfSel) bitIdx <= (bitIdx == LAST_IDX) ? '0 : bitIdx + IDX_W'(1);
    end
  end

  assign tick = started && (halfCnt == '0);

  always_comb begin
    strb.firstFrame = enable && !started;
    strb.loadFrame  = strb.firstFrame || (enable && tick && halfSel && bitIdx == LAST_IDX);
    strb.shift      = enable && tick && halfSel && bitIdx != LAST_IDX;
    strb.midBit     = enable && tick && !halfSel;
  end

  AST_HALF_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.midBit |=> (halfCnt == $past(effDiv)));  // R1
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    bitIdx <= LAST_IDX);  // R4
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.loadFrame, strb.shift, strb.midBit}));  // R3

endmodule

// File: rtl/ltc_frame_path.sv
module ltc_frame_path
  import ltc_gen_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  ctrlStrb_t  strb,
  input  logic [1:0] rateSel,
  input  logic       dropFrame,
  input  logic       freewheel,
  input  logic       loadStb,
  input  tcWord_t    loadTime,
  output logic       ltcOut,
  output logic       frameStart
);

  tcWord_t               nextTime, curTime, sendTime;
  logic                  pending;
  logic [FRAME_BITS-1:0] shReg;

  always_comb begin
    if (pending)                           sendTime = nextTime;
    else if (freewheel && !strb.firstFrame) sendTime = stepTime(curTime, rateSel, dropFrame);
    else                                   sendTime = curTime;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nextTime   <= '0;
      curTime    <= '0;
      pending    <= 1'b0;
      shReg      <= '0;
      ltcOut     <= 1'b0;
      frameStart <= 1'b0;
    end else begin
      if (loadStb) nextTime <= loadTime;
      if (loadStb)             pending <= 1'b1;
      else if (strb.loadFrame) pending <= 1'b0;

      if (strb.loadFrame) begin
        curTime <= sendTime;
        shReg   <= packFrame(sendTime, dropFrame);
      end else if (strb.shift) begin
        shReg <= {1'b0, shReg[FRAME_BITS-1:1]};
      end

      if (strb.loadFrame || strb.shift)  ltcOut <= ~ltcOut;
      else if (strb.midBit && shReg[0]) ltcOut <= ~ltcOut;

      frameStart <= strb.loadFrame;
    end
  end

  AST_FS_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> !frameStart);  // R6
  AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.loadFrame || strb.shift || strb.midBit) |=> $stable(ltcOut));  // R3
  AST_ZERO_MID: assert property (@(posedge clk) disable iff (!rstN)
    (strb.midBit && !shReg[0]) |=> $stable(ltcOut));  // R3
  AST_PENDING_DRAIN: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadFrame && !loadStb) |=> !pending);  // R5
  AST_FRAME_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadFrame |=> (shReg[FRAME_BITS-1 -: 16] == SYNC_WORD));  // R4

endmodule

// File: rtl/ltc_frame_gen.sv
module ltc_frame_gen
  import ltc_gen_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic [1:0] rateSel,
  input  logic       dropFrame,
  input  logic       freewheel,
  input  logic       divWrEn,
  input  logic       divWrAddr,
  input  logic [7:0] divWrData,
  input  logic       loadStb,
  input  logic [4:0] loadHours,
  input  logic [5:0] loadMins,
  input  logic [5:0] loadSecs,
  input  logic [4:0] loadFrames,
  output logic       ltcOut,
  output logic       frameStart
);

  ctrlStrb_t strb;
  tcWord_t   loadTime;

  assign loadTime = '{hours: loadHours, mins: loadMins, secs: loadSecs, frames: loadFrames};

  ltc_bit_timer #(.DIV_W(DIV_W)) i_timer (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .rateSel   (rateSel),
    .divWrEn   (divWrEn),
    .divWrAddr (divWrAddr),
    .divWrData (divWrData),
    .strb      (strb)
  );

  ltc_frame_path i_path (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .rateSel    (rateSel),
    .dropFrame  (dropFrame),
    .freewheel  (freewheel),
    .loadStb    (loadStb),
    .loadTime   (loadTime),
    .ltcOut     (ltcOut),
    .frameStart (frameStart)
  );

endmodule

// File: tb/test_ltc_frame_gen.sv
`timescale 1ns/1ps
module test_ltc_frame_gen;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic [1:0] rateSel = 2'd0;
  logic       dropFrame = 1'b0, freewheel = 1'b0;
  logic       divWrEn = 1'b0, divWrAddr = 1'b0;
  logic [7:0] divWrData = '0;
  logic       loadStb = 1'b0;
  logic [4:0] loadHours = '0, loadFrames = '0;
  logic [5:0] loadMins = '0, loadSecs = '0;
  logic       ltcOut, frameStart;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic lastLvl = 1'b0;
  int waitCyc;
  bit boundaryOk;
  logic [79:0] fa, fb;

  always #2 clk = ~clk;

  ltc_frame_gen i_ltc_frame_gen (
    .clk(clk), .rstN(rstN), .enable(enable), .rateSel(rateSel), .dropFrame(dropFrame),
    .freewheel(freewheel), .divWrEn(divWrEn), .divWrAddr(divWrAddr), .divWrData(divWrData),
    .loadStb(loadStb), .loadHours(loadHours), .loadMins(loadMins), .loadSecs(loadSecs),
    .loadFrames(loadFrames), .ltcOut(ltcOut), .frameStart(frameStart)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doLoad(input int h, input int m, input int s, input int f);
    @(negedge clk);
    loadStb = 1'b1; loadHours = 5'(h); loadMins = 6'(m); loadSecs = 6'(s); loadFrames = 5'(f);
    @(negedge clk);
    loadStb = 1'b0;
  endtask

  task automatic divWrite(input bit hi, input logic [7:0] val);
    @(negedge clk);
    divWrEn = 1'b1; divWrAddr = hi; divWrData = val;
    @(negedge clk);
    divWrEn = 1'b0;
  endtask

  task automatic restart();
    @(negedge clk);
    enable = 1'b0;
    cyc(3);
    enable = 1'b1;
  endtask

  task automatic waitStart();
    waitCyc = 0;
    while (!frameStart) begin
      lastLvl = ltcOut;
      @(negedge clk);
      waitCyc++;
    end
  endtask

  // samples the first cycle of every half-bit, h cycles per half
  task automatic readFrame(input int h, output logic [79:0] bits);
    logic a, b;
    waitStart();
    boundaryOk = 1'b1;
    for (int i = 0; i < 80; i++) begin
      a = ltcOut;
      if (a == lastLvl) boundaryOk = 1'b0;
      cyc(h);
      b = ltcOut;
      cyc(h);
      bits[i] = a ^ b;
      lastLvl = b;
    end
  endtask

  task automatic measureHalf(output int n);
    logic a;
    waitStart();
    a = ltcOut;
    n = 0;
    while (ltcOut == a) begin
      @(negedge clk);
      n++;
    end
  endtask

  function automatic int decode(input logic [79:0] b);
    int f, s, m, h;
    f = int'(b[9:8]) * 10 + int'(b[3:0]);
    s = int'(b[26:24]) * 10 + int'(b[19:16]);
    m = int'(b[42:40]) * 10 + int'(b[35:32]);
    h = int'(b[57:56]) * 10 + int'(b[51:48]);
    return h * 1000000 + m * 10000 + s * 100 + f;
  endfunction

  function automatic logic [79:0] spareBits(input logic [79:0] b);
    logic [79:0] m;
    m = '1;
    m[3:0] = '0; m[9:8] = '0; m[10] = 1'b0; m[19:16] = '0; m[26:24] = '0;
    m[35:32] = '0; m[42:40] = '0; m[51:48] = '0; m[57:56] = '0; m[79:64] = '0;
    return b & m;
  endfunction

  task automatic t_reset();
    logic lvl;
    int spurious = 0;
    check(ltcOut == 1'b0, "R12", "ltcOut after reset", ltcOut, 0);
    check(frameStart == 1'b0, "R12", "frameStart after reset", frameStart, 0);
    lvl = ltcOut;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (frameStart || ltcOut != lvl) spurious++;
    end
    check(spurious == 0, "R11", "activity while disabled", spurious, 0);
  endtask

  task automatic t_divider();
    int n;
    doLoad(0, 0, 0, 1);
    rateSel = 2'd2; restart(); measureHalf(n);
    check(n == 32'h0DFB + 1, "R1", "default half-bit at 25 fps", n, 32'h0DFB + 1);
    rateSel = 2'd1; restart(); measureHalf(n);
    check(n == 32'h0BA9 + 1, "R1", "default half-bit at 29.97 fps", n, 32'h0BA9 + 1);
    divWrite(1'b0, 8'd3);
    rateSel = 2'd0; restart(); measureHalf(n);
    check(n == 32'h0BA6 + 1, "R2", "low byte alone kept 30 fps default", n, 32'h0BA6 + 1);
    divWrite(1'b1, 8'd0);
    rateSel = 2'd3; restart(); measureHalf(n);
    check(n == 4, "R2", "committed divider 3 overrides rate", n, 4);
  endtask

  task automatic t_layout();
    freewheel = 1'b0; dropFrame = 1'b0; rateSel = 2'd0;
    enable = 1'b0;
    doLoad(12, 34, 56, 17);
    restart(); readFrame(4, fa);
    check(decode(fa) == 12345617, "R4", "decoded fields", decode(fa), 12345617);
    check(fa[79:64] == 16'hBFFC, "R4", "sync field", fa[79:64], 16'hBFFC);
    check(spareBits(fa) == '0, "R4", "unused bits zero", 64'(spareBits(fa)), 0);
    check(fa[10] == 1'b0, "R4", "drop flag clear", fa[10], 0);
    check(boundaryOk, "R3", "boundary transitions", boundaryOk, 1);
    check(waitCyc == 1, "R11", "first frame starts on enable", waitCyc, 1);
  endtask

  task automatic t_dbuf();
    freewheel = 1'b0; enable = 1'b0;
    doLoad(1, 2, 3, 4);
    restart(); readFrame(4, fa);
    fork
      readFrame(4, fb);
      begin cyc(200); doLoad(5, 6, 7, 8); end
    join
    check(decode(fb) == 1020304, "R5", "frame in flight unchanged", decode(fb), 1020304);
    check(waitCyc == 0, "R6", "frames back to back", waitCyc, 0);
    readFrame(4, fa);
    check(decode(fa) == 5060708, "R5", "buffered word sent next", decode(fa), 5060708);
    readFrame(4, fa);
    check(decode(fa) == 5060708, "R10", "held code repeated", decode(fa), 5060708);
    fork
      readFrame(4, fb);
      begin cyc(100); doLoad(9, 10, 11, 12); cyc(100); doLoad(13, 14, 15, 16); end
    join
    readFrame(4, fa);
    check(decode(fa) == 13141516, "R5", "last load wins", decode(fa), 13141516);
  endtask

  task automatic freeRun(input logic [1:0] rate, input int f0, input int e1, input int e2,
                         input string what);
    rateSel = rate; freewheel = 1'b1; enable = 1'b0;
    doLoad(0, 0, 0, f0);
    restart(); readFrame(4, fa);
    check(decode(fa) == f0, "R11", {what, " first frame not stepped"}, decode(fa), f0);
    readFrame(4, fa);
    check(decode(fa) == e1, "R7", {what, " step"}, decode(fa), e1);
    readFrame(4, fa);
    check(decode(fa) == e2, "R7", {what, " wrap"}, decode(fa), e2);
  endtask

  task automatic t_rollover();
    rateSel = 2'd0; freewheel = 1'b1; enable = 1'b0;
    doLoad(23, 59, 59, 29);
    restart(); readFrame(4, fa); readFrame(4, fa);
    check(decode(fa) == 0, "R8", "day rollover", decode(fa), 0);
  endtask

  task automatic t_drop();
    rateSel = 2'd1; freewheel = 1'b1; dropFrame = 1'b1; enable = 1'b0;
    doLoad(0, 0, 59, 29);
    restart(); readFrame(4, fa);
    check(fa[10] == 1'b1, "R9", "drop flag set", fa[10], 1);
    readFrame(4, fa);
    check(decode(fa) == 10002, "R9", "minute 1 skips frames 0 and 1", decode(fa), 10002);
    enable = 1'b0;
    doLoad(0, 9, 59, 29);
    restart(); readFrame(4, fa); readFrame(4, fa);
    check(decode(fa) == 100000, "R9", "minute 10 keeps frame 0", decode(fa), 100000);
    dropFrame = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R6 watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    cyc(3);
    rstN = 1'b1;
    cyc(1);
    t_reset();
    t_divider();
    t_layout();
    t_dbuf();
    freeRun(2'd2, 23, 24, 100, "25 fps");
    freeRun(2'd3, 22, 23, 100, "24 fps");
    freeRun(2'd0, 28, 29, 100, "30 fps");
    t_rollover();
    t_drop();
    done = 1'b1;
    summary();
    $finish;
  end

endmodule